// File: doc/BRIEF.md
# Receive/Transmit DMA Control and Status Registers

This block is the host-visible register set that sits between a processor bus and a pair of descriptor-driven DMA engines, one for receive and one for transmit. It keeps the MAC configuration word, the DMA control word with a start bit for each direction, an interrupt enable mask and a status word. The status word combines latched event flags with two 3-bit process-state fields, one per direction.

Host writes move the process-state fields. A write to the control word starts or stops each direction. A write to the receive poll-demand address, whatever data it carries, puts the receive side back into waiting. A write of one to the buffer-unavailable flag clears that flag and re-arms the receive side. The DMA engines can set event flags and load either state field in any cycle, and an engine request always beats a host request made in the same cycle. The block produces single-cycle pulses that tell the engines to retry queued receive frames or to try the next transmit frame. It also produces a receive-permit level and an interrupt level.

Top module: `dmacsr_top`

## Requirements
- R1: After reset every register reads zero, both state fields read 0 (stopped), `irq` is 0 and `rx_allow` is 0.
- R2: A write to the control word (word address 1) with bit 0 set loads the receive state with 3 (waiting) and raises `rx_retry` for exactly one cycle. A write with bit 0 clear loads it with 0 (stopped) and raises no pulse.
- R3: A write to the control word with bit 1 set raises `tx_kick` for one cycle and leaves the transmit state as it was. A write with bit 1 clear loads the transmit state with 0 (stopped).
- R4: A write of any data to the poll-demand address (word address 2) loads the receive state with 3 (waiting) and raises no `rx_retry`.
- R5: A write to the status word (word address 3) clears each event flag in bits [7:0] whose data bit is 1 and keeps the others. The data bits written over the state fields (receive state at bits [19:17], transmit state at bits [22:20]) change nothing.
- R6: A status write with bit 7 (buffer unavailable) set clears that flag, loads the receive state with 3 (waiting) and raises `rx_retry` for one cycle.
- R7: `rx_allow` is 1 exactly when bit 2 of the MAC configuration word (word address 0) and bit 0 of the control word are both 1.
- R8: An engine flag set takes effect at the next clock edge. It wins over a host clear of the same flag in that cycle.
- R9: An engine load of a state field wins over any host request for that field in the same cycle.
- R10: `irq` is the OR over the event flags ANDed with the enable mask (word address 4, bits [7:0]). It follows the registers with no added cycle.
- R11: `rd_data` shows the word selected by `rd_addr` one clock later. Unmapped addresses read zero.
- R12: Writes to unmapped addresses change no register, state or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write word address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 4 | Host read word address |
| rd_data | output | 32 | Registered read data |
| eng_evt_set | input | 8 | Engine requests to set event flags |
| eng_rx_st_we | input | 1 | Engine load of receive state |
| eng_rx_st | input | 3 | Receive state value to load |
| eng_tx_st_we | input | 1 | Engine load of transmit state |
| eng_tx_st | input | 3 | Transmit state value to load |
| rx_allow | output | 1 | Receive permitted (enable and start both set) |
| rx_go | output | 1 | Receive start bit |
| tx_go | output | 1 | Transmit start bit |
| rx_retry | output | 1 | One-cycle request to retry queued receive frames |
| tx_kick | output | 1 | One-cycle request to try the next transmit frame |
| irq | output | 1 | Interrupt level |

## Verification
The assertions assume that the host issues at most one write per cycle, that engine requests are valid only while reset is low, and that engine state values are drawn from the defined encodings. The bench drives every input at the falling edge from a single task, so each write and engine request occupies exactly one cycle. It applies engine requests only after reset has been released and uses only the state codes 0, 3, 4 and 7.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  typedef logic [2:0] pstate_t;
  localparam pstate_t PS_STOP  = 3'd0;
  localparam pstate_t PS_FETCH = 3'd1;
  localparam pstate_t PS_WAIT  = 3'd3;
  localparam pstate_t PS_SUSP  = 3'd4;
  localparam pstate_t PS_CLOSE = 3'd5;
  localparam pstate_t PS_XFER  = 3'd7;

  localparam int WA_CFG  = 0;
  localparam int WA_CTL  = 1;
  localparam int WA_POLL = 2;
  localparam int WA_STS  = 3;
  localparam int WA_IEN  = 4;

  localparam int CFG_RXEN_BIT = 2;
  localparam int CTL_RXGO_BIT = 0;
  localparam int CTL_TXGO_BIT = 1;
endpackage

// File: rtl/pstate_reg.sv
module pstate_reg
  import dmacsr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    host_we,
  input  pstate_t host_val,
  input  logic    eng_we,
  input  pstate_t eng_val,
  output pstate_t q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= PS_STOP;
    else if (eng_we)  q <= eng_val;
    else if (host_we) q <= host_val;
  end

  // R9: engine load takes priority
  assert_eng_wins_R9: assert property (@(posedge clk) disable iff (rst)
    eng_we |=> q == $past(eng_val));
  assert_host_load_R2: assert property (@(posedge clk) disable iff (rst)
    (host_we && !eng_we) |=> q == $past(host_val));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!host_we && !eng_we) |=> $stable(q));
endmodule

// File: rtl/evt_flags.sv
module evt_flags #(
  parameter int NEVT = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] set,
  input  logic            clr_we,
  input  logic [NEVT-1:0] clr_mask,
  output logic [NEVT-1:0] q
);
  for (genvar i = 0; i < NEVT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                      q[i] <= 1'b0;
      else if (set[i])              q[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) q[i] <= 1'b0;
    end
  end

  // R8: a requested set is visible next cycle, even against a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    |set |=> ((q & $past(set)) == $past(set)));
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & ~$past(q) & ~$past(set)) == '0));
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_we && (clr_mask & ~set) != '0) |=> ((q & $past(clr_mask & ~set)) == '0));
endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
  import dmacsr_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 32,
  parameter int NEVT    = 8,
  parameter int BU_IDX  = 7,
  parameter int RXS_LSB = 17,
  parameter int TXS_LSB = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [NEVT-1:0] eng_evt_set,
  input  logic            eng_rx_st_we,
  input  logic [2:0]      eng_rx_st,
  input  logic            eng_tx_st_we,
  input  logic [2:0]      eng_tx_st,
  output logic            rx_allow,
  output logic            rx_go,
  output logic            tx_go,
  output logic            rx_retry,
  output logic            tx_kick,
  output logic            irq
);
  localparam logic [AW-1:0] A_CFG  = AW'(WA_CFG);
  localparam logic [AW-1:0] A_CTL  = AW'(WA_CTL);
  localparam logic [AW-1:0] A_POLL = AW'(WA_POLL);
  localparam logic [AW-1:0] A_STS  = AW'(WA_STS);
  localparam logic [AW-1:0] A_IEN  = AW'(WA_IEN);

  logic [DW-1:0]   cfg_q, ctl_q;
  logic [NEVT-1:0] ien_q, evt_q;
  pstate_t         rxs_q, txs_q;

  logic cfg_wr, ctl_wr, poll_wr, sts_wr, ien_wr;
  assign cfg_wr  = wr_en && (wr_addr == A_CFG);
  assign ctl_wr  = wr_en && (wr_addr == A_CTL);
  assign poll_wr = wr_en && (wr_addr == A_POLL);
  assign sts_wr  = wr_en && (wr_addr == A_STS);
  assign ien_wr  = wr_en && (wr_addr == A_IEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ctl_q <= '0;
      ien_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= wr_data;
      if (ctl_wr) ctl_q <= wr_data;
      if (ien_wr) ien_q <= wr_data[NEVT-1:0];
    end
  end

  // receive state requests from the host
  logic    rx_host_we;
  pstate_t rx_host_val;
  always_comb begin
    rx_host_we  = ctl_wr || poll_wr || (sts_wr && wr_data[BU_IDX]);
    rx_host_val = PS_WAIT;
    if (ctl_wr && !wr_data[CTL_RXGO_BIT]) rx_host_val = PS_STOP;
  end

  logic tx_host_we;
  assign tx_host_we = ctl_wr && !wr_data[CTL_TXGO_BIT];

  pstate_reg u_rxs (
    .clk(clk), .rst(rst),
    .host_we(rx_host_we), .host_val(rx_host_val),
    .eng_we(eng_rx_st_we), .eng_val(eng_rx_st),
    .q(rxs_q)
  );

  pstate_reg u_txs (
    .clk(clk), .rst(rst),
    .host_we(tx_host_we), .host_val(PS_STOP),
    .eng_we(eng_tx_st_we), .eng_val(eng_tx_st),
    .q(txs_q)
  );

  evt_flags #(.NEVT(NEVT)) u_evt (
    .clk(clk), .rst(rst),
    .set(eng_evt_set),
    .clr_we(sts_wr), .clr_mask(wr_data[NEVT-1:0]),
    .q(evt_q)
  );

  // strobes to the engines
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_retry <= 1'b0;
      tx_kick  <= 1'b0;
    end else begin
      rx_retry <= (ctl_wr && wr_data[CTL_RXGO_BIT]) || (sts_wr && wr_data[BU_IDX]);
      tx_kick  <= ctl_wr && wr_data[CTL_TXGO_BIT];
    end
  end

  assign rx_go    = ctl_q[CTL_RXGO_BIT];
  assign tx_go    = ctl_q[CTL_TXGO_BIT];
  assign rx_allow = cfg_q[CFG_RXEN_BIT] && ctl_q[CTL_RXGO_BIT];
  assign irq      = |(evt_q & ien_q);

  // status word assembly and registered read port
  logic [DW-1:0] sts_word;
  always_comb begin
    sts_word = '0;
    sts_word[NEVT-1:0] = evt_q;
    sts_word[RXS_LSB +: 3] = rxs_q;
    sts_word[TXS_LSB +: 3] = txs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CFG:   rd_data <= cfg_q;
        A_CTL:   rd_data <= ctl_q;
        A_STS:   rd_data <= sts_word;
        A_IEN:   rd_data <= DW'(ien_q);
        default: rd_data <= '0;
      endcase
    end
  end

  assert_kick_cause_R3: assert property (@(posedge clk) disable iff (rst)
    tx_kick |-> $past(ctl_wr && wr_data[CTL_TXGO_BIT]));
  assert_retry_cause_R6: assert property (@(posedge clk) disable iff (rst)
    rx_retry |-> $past(wr_en && (wr_addr == A_CTL || wr_addr == A_STS)));
  assert_rx_start_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wr_data[CTL_RXGO_BIT] && !eng_rx_st_we) |=> (rxs_q == PS_WAIT) && rx_retry);
  assert_poll_R4: assert property (@(posedge clk) disable iff (rst)
    (poll_wr && !eng_rx_st_we) |=> (rxs_q == PS_WAIT) && !rx_retry);
  assert_unmapped_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > A_IEN && eng_evt_set == '0 && !eng_rx_st_we && !eng_tx_st_we)
      |=> $stable(cfg_q) && $stable(ctl_q) && $stable(ien_q) && $stable(sts_word));
endmodule

// File: tb/sim_dmacsr_top.sv
module sim_dmacsr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  eng_evt_set = '0;
  logic        eng_rx_st_we = 1'b0, eng_tx_st_we = 1'b0;
  logic [2:0]  eng_rx_st = '0, eng_tx_st = '0;
  logic        rx_allow, rx_go, tx_go, rx_retry, tx_kick, irq;

  int errs = 0, checks = 0;
  logic p_retry, p_kick, p_irq;

  always #2 clk = ~clk;

  dmacsr_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .eng_evt_set(eng_evt_set),
    .eng_rx_st_we(eng_rx_st_we), .eng_rx_st(eng_rx_st),
    .eng_tx_st_we(eng_tx_st_we), .eng_tx_st(eng_tx_st),
    .rx_allow(rx_allow), .rx_go(rx_go), .tx_go(tx_go),
    .rx_retry(rx_retry), .tx_kick(tx_kick), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of host write and/or engine requests
  task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d,
                     input logic [7:0] es, input logic rwe, input logic [2:0] rv,
                     input logic twe, input logic [2:0] tv);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    eng_evt_set = es; eng_rx_st_we = rwe; eng_rx_st = rv;
    eng_tx_st_we = twe; eng_tx_st = tv;
    @(posedge clk); #1;
    p_retry = rx_retry; p_kick = tx_kick; p_irq = irq;
    @(negedge clk);
    wr_en = 0; eng_evt_set = '0; eng_rx_st_we = 0; eng_tx_st_we = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(posedge clk); #1; v = rd_data;
  endtask

  function automatic logic [31:0] sts(input logic [7:0] e, input logic [2:0] r, input logic [2:0] t);
    return {9'b0, t, r, 9'b0, e};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin rd(4'(a), v); chk("R1 reset read", v, 0); end
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rx_allow", {31'b0, rx_allow}, 0);
  endtask

  task automatic t_ctl();
    logic [31:0] v;
    wr(4'd1, 32'h1);
    chk("R2 retry pulse", {31'b0, p_retry}, 1);
    chk("R2 rx_go", {31'b0, rx_go}, 1);
    @(negedge clk); #1;
    chk("R2 retry one cycle", {31'b0, rx_retry}, 0);
    rd(4'd3, v); chk("R2 rx waiting", v, sts(0, 3'd3, 3'd0));
    cyc(1'b0, 0, 0, 0, 1'b0, 0, 1'b1, 3'd7);
    wr(4'd1, 32'h3);
    chk("R3 kick pulse", {31'b0, p_kick}, 1);
    rd(4'd3, v); chk("R3 tx state kept", v, sts(0, 3'd3, 3'd7));
    wr(4'd1, 32'h0);
    chk("R2 no retry on stop", {31'b0, p_retry}, 0);
    chk("R3 no kick on stop", {31'b0, p_kick}, 0);
    rd(4'd3, v); chk("R2 R3 both stopped", v, sts(0, 3'd0, 3'd0));
  endtask

  task automatic t_allow();
    wr(4'd0, 32'h4); chk("R7 enable only", {31'b0, rx_allow}, 0);
    wr(4'd1, 32'h1); chk("R7 both set", {31'b0, rx_allow}, 1);
    wr(4'd0, 32'h0); chk("R7 start only", {31'b0, rx_allow}, 0);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_poll();
    logic [31:0] v;
    cyc(1'b0, 0, 0, 0, 1'b1, 3'd4, 1'b0, 0);
    wr(4'd2, 32'h0);
    chk("R4 no retry", {31'b0, p_retry}, 0);
    rd(4'd3, v); chk("R4 poll to waiting", v, sts(0, 3'd3, 0));
    cyc(1'b0, 0, 0, 0, 1'b1, 3'd4, 1'b0, 0);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd3, v); chk("R4 any data", v, sts(0, 3'd3, 0));
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    cyc(1'b0, 0, 0, 8'h5A, 1'b0, 0, 1'b0, 0);
    wr(4'd3, 32'h0070_0012 | (32'h7 << 17));
    rd(4'd3, v); chk("R5 w1c and fields kept", v, sts(8'h48, 3'd3, 0));
    chk("R5 no retry", {31'b0, p_retry}, 0);
    wr(4'd3, 32'hFF);
  endtask

  task automatic t_bu();
    logic [31:0] v;
    cyc(1'b0, 0, 0, 8'h81, 1'b1, 3'd4, 1'b0, 0);
    wr(4'd3, 32'h80);
    chk("R6 retry pulse", {31'b0, p_retry}, 1);
    rd(4'd3, v); chk("R6 bu cleared rx waiting", v, sts(8'h01, 3'd3, 0));
    wr(4'd3, 32'hFF);
  endtask

  task automatic t_race();
    logic [31:0] v;
    cyc(1'b1, 4'd3, 32'h02, 8'h02, 1'b0, 0, 1'b0, 0);
    rd(4'd3, v); chk("R8 set beats clear", v, sts(8'h02, 3'd3, 0));
    cyc(1'b1, 4'd2, 32'h0, 8'h00, 1'b1, 3'd4, 1'b0, 0);
    rd(4'd3, v); chk("R9 rx engine wins", v, sts(8'h02, 3'd4, 0));
    cyc(1'b1, 4'd1, 32'h0, 8'h00, 1'b0, 0, 1'b1, 3'd7);
    rd(4'd3, v); chk("R9 tx engine wins", v, sts(8'h02, 3'd0, 3'd7));
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(4'd3, 32'hFF);
    wr(4'd4, 32'h02);
    chk("R10 no flag", {31'b0, p_irq}, 0);
    rd(4'd4, v); chk("R11 enable readback", v, 32'h02);
    cyc(1'b0, 0, 0, 8'h02, 1'b0, 0, 1'b0, 0);
    chk("R10 same cycle as flag", {31'b0, p_irq}, 1);
    cyc(1'b0, 0, 0, 8'h01, 1'b0, 0, 1'b0, 0);
    wr(4'd4, 32'h00);
    chk("R10 masked", {31'b0, p_irq}, 0);
    wr(4'd4, 32'h01);
    chk("R10 other bit", {31'b0, p_irq}, 1);
    wr(4'd3, 32'h03);
    chk("R10 cleared", {31'b0, p_irq}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] b0, b1, b3, v;
    rd(4'd0, b0); rd(4'd1, b1); rd(4'd3, b3);
    wr(4'd9, 32'hFFFF_FFFF);
    chk("R12 no retry", {31'b0, p_retry}, 0);
    chk("R12 no kick", {31'b0, p_kick}, 0);
    rd(4'd0, v); chk("R12 cfg kept", v, b0);
    rd(4'd1, v); chk("R12 ctl kept", v, b1);
    rd(4'd3, v); chk("R12 status kept", v, b3);
    rd(4'd9, v); chk("R11 unmapped reads zero", v, 0);
    rd(4'd2, v); chk("R11 poll reads zero", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_ctl();
    t_allow();
    t_poll();
    t_w1c();
    t_bu();
    t_race();
    t_irq();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule